// File: doc/BRIEF.md
# Watermark Burst Request Controller

This block sits between a card-side data FIFO and a memory bus master. For each buffer job (start address, byte count, direction) it decides when the next memory transaction may start and how many beats it carries. It then issues that transaction as a single request on a valid/ready handshake and waits for the bus to report completion before it plans the next one.

In the receive direction the FIFO holds card data, and the block writes it to memory. In the transmit direction it reads memory to refill the FIFO. Full bursts wait until the FIFO fill level or free space reaches a programmable byte threshold. The tail of a buffer that is too short for a full burst moves as one-beat transfers.

After a stop command the block switches to one-beat transfers and keeps moving data, past the end of the buffer if needed. It continues until the data-transfer-over pulse arrives. This keeps the card clock running on writes and empties the FIFO on reads.

Top module: `wmark_burst_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, `req_valid` and `job_done` are low.
- R2: In the receive direction (`job_dir`=0), a burst request is only raised if, in the cycle before, `fifo_fill` was at least the larger of `rx_mark` and the burst size in bytes.
- R3: In the transmit direction (`job_dir`=1), a burst request is only raised if, in the cycle before, `fifo_space` was at least the larger of `tx_mark` and the burst size in bytes.
- R4: `burst_sel` codes 0, 1, 2 and 3 select bursts of 1, 4, 8 and 16 beats of 4 bytes each. When the burst size in bytes exceeds the bytes left in the buffer, the request has 1 beat. A 1-beat request needs only 4 bytes of fill (receive) or free space (transmit).
- R5: The first request carries `job_addr`. Each accepted request advances the address by beats×4 and lowers the remaining count by the same amount, saturating at zero. `req_write` is 1 for the receive direction.
- R6: Without a stop, `job_done` pulses high for exactly one cycle after the transaction that brings the remaining count to zero completes. A zero-byte job ends with no request.
- R7: Once `stop_pulse` is seen during a job, every request raised afterwards has 1 beat, gated on 4 bytes of fill or free space.
- R8: After a stop, requests keep coming even past the end of the buffer. The job ends with `job_done` only after `dto_pulse` is seen and the outstanding transaction completes, and no further request is raised.
- R9: At most one transaction is outstanding: `req_valid` stays low from an accepted request until `txn_done`.
- R10: A raised request keeps `req_valid`, `req_addr` and `req_beats` unchanged until `req_ready`.
- R11: `dto_pulse` has no effect on a job with no stop, and `stop_pulse` has no effect while no job is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| job_start | input | 1 | Starts a job when idle |
| job_addr | input | ADDR_W | Buffer start address |
| job_bytes | input | CNT_W | Buffer byte count, multiple of 4 |
| job_dir | input | 1 | 0 receive (FIFO to memory), 1 transmit |
| fifo_fill | input | LVL_W | Bytes held in the FIFO |
| fifo_space | input | LVL_W | Free bytes in the FIFO |
| rx_mark | input | LVL_W | Receive fill threshold in bytes |
| tx_mark | input | LVL_W | Transmit free-space threshold in bytes |
| burst_sel | input | 2 | Burst length code |
| stop_pulse | input | 1 | Stop command seen |
| dto_pulse | input | 1 | Data-transfer-over event |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Bus master accepts the request |
| req_addr | output | ADDR_W | Request address |
| req_beats | output | 5 | Request beat count |
| req_write | output | 1 | 1 for a memory write |
| txn_done | input | 1 | Outstanding transaction finished |
| job_done | output | 1 | One-cycle job completion |

## Verification
The hardest situation to reach is an abort that outlives the buffer. A stop has to land while a burst is in flight. The FIFO must then be starved below one beat and released, and the stream of single requests must be allowed to run beyond the original byte count before data-transfer-over is delivered during an outstanding transaction. The bench reaches this with directed jobs that pulse the stop and the transfer-over event inside the completion wait of chosen request indices. It adds random jobs whose stop and transfer-over indices are drawn relative to the modelled request count.

// File: rtl/wmb_pkg.sv
package wmb_pkg;

   localparam int BEAT_W = 5;

   localparam logic DIR_RX = 1'b0;
   localparam logic DIR_TX = 1'b1;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_ARM,
      WS_ISSUE,
      WS_WAIT,
      WS_DONE
   } wmb_state_e;

   // burst length code to beat count
   function automatic logic [BEAT_W-1:0] burst_beats(input logic [1:0] sel);
      logic [BEAT_W-1:0] b;
      case (sel)
         2'd0:    b = 5'd1;
         2'd1:    b = 5'd4;
         2'd2:    b = 5'd8;
         default: b = 5'd16;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/wmb_gate.sv
module wmb_gate #(
   parameter int CNT_W       = 16,
   parameter int LVL_W       = 12,
   parameter int BEAT_BYTES  = 4,
   parameter bit BURST_FLOOR = 1'b1
) (
   input  logic                       dir,
   input  logic                       aborting,
   input  logic [1:0]                 sel,
   input  logic [CNT_W-1:0]           remaining,
   input  logic [LVL_W-1:0]           fill,
   input  logic [LVL_W-1:0]           space,
   input  logic [LVL_W-1:0]           rx_mark,
   input  logic [LVL_W-1:0]           tx_mark,
   output logic                       go,
   output logic [wmb_pkg::BEAT_W-1:0] beats
);
   import wmb_pkg::*;

   localparam int CMP_W = ((LVL_W > CNT_W) ? LVL_W : CNT_W) + 1;

   logic [BEAT_W-1:0] full_beats;
   logic [CMP_W-1:0]  full_bytes;
   logic [CMP_W-1:0]  rem_w;
   logic [CMP_W-1:0]  level_w;
   logic [CMP_W-1:0]  mark_w;
   logic [CMP_W-1:0]  burst_need;
   logic [CMP_W-1:0]  need_w;
   logic              single;

   always_comb begin
      full_beats = burst_beats(sel);
      full_bytes = CMP_W'(full_beats) * CMP_W'(BEAT_BYTES);
      rem_w      = CMP_W'(remaining);
      single     = aborting || (full_bytes > rem_w);
      beats      = single ? BEAT_W'(1) : full_beats;
      level_w    = (dir == DIR_TX) ? CMP_W'(space) : CMP_W'(fill);
      mark_w     = (dir == DIR_TX) ? CMP_W'(tx_mark) : CMP_W'(rx_mark);
   end

   // variant: whether a burst also waits for its own size in bytes
   generate
      if (BURST_FLOOR) begin : g_floor
         always_comb burst_need = (mark_w > full_bytes) ? mark_w : full_bytes;
      end else begin : g_mark_only
         always_comb burst_need = mark_w;
      end
   endgenerate

   always_comb begin
      need_w = single ? CMP_W'(BEAT_BYTES) : burst_need;
      go     = (level_w >= need_w);
   end

endmodule

// File: rtl/wmb_cursor.sv
module wmb_cursor #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int BEAT_BYTES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [ADDR_W-1:0]          load_addr,
   input  logic [CNT_W-1:0]           load_bytes,
   input  logic                       step,
   input  logic [wmb_pkg::BEAT_W-1:0] step_beats,
   output logic [ADDR_W-1:0]          addr,
   output logic [CNT_W-1:0]           remaining
);
   logic [CNT_W-1:0]  step_cnt;
   logic [ADDR_W-1:0] step_addr;

   always_comb begin
      step_cnt  = CNT_W'(step_beats) * CNT_W'(BEAT_BYTES);
      step_addr = ADDR_W'(step_beats) * ADDR_W'(BEAT_BYTES);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr      <= '0;
         remaining <= '0;
      end else if (load) begin
         addr      <= load_addr;
         remaining <= load_bytes;
      end else if (step) begin
         addr      <= addr + step_addr;
         remaining <= (remaining > step_cnt) ? (remaining - step_cnt) : '0;
      end
   end

endmodule

// File: rtl/wmb_seq.sv
module wmb_seq #(
   parameter int CNT_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       job_start,
   input  logic                       job_dir,
   input  logic                       stop_pulse,
   input  logic                       dto_pulse,
   input  logic                       go,
   input  logic [wmb_pkg::BEAT_W-1:0] beats_in,
   input  logic [CNT_W-1:0]           remaining,
   input  logic                       req_ready,
   input  logic                       txn_done,
   output logic                       load,
   output logic                       step,
   output logic                       abort_eff,
   output logic                       abort_q,
   output logic                       dir_q,
   output logic                       req_valid,
   output logic [wmb_pkg::BEAT_W-1:0] req_beats,
   output logic                       job_done
);
   import wmb_pkg::*;

   wmb_state_e        state;
   wmb_state_e        nxt;
   logic              dto_q;
   logic              active;
   logic              finish;
   logic [BEAT_W-1:0] beats_q;

   always_comb begin
      active    = (state == WS_ARM) || (state == WS_ISSUE) || (state == WS_WAIT);
      abort_eff = abort_q || (active && stop_pulse);
      finish    = abort_q ? dto_q : (remaining == '0);
      load      = (state == WS_IDLE) && job_start;
      step      = (state == WS_ISSUE) && req_ready;
      req_valid = (state == WS_ISSUE);
      job_done  = (state == WS_DONE);
      req_beats = beats_q;
   end

   always_comb begin
      nxt = state;
      unique case (state)
         WS_IDLE:  if (job_start) nxt = WS_ARM;
         WS_ARM: begin
            if (finish)  nxt = WS_DONE;
            else if (go) nxt = WS_ISSUE;
         end
         WS_ISSUE: if (req_ready) nxt = WS_WAIT;
         WS_WAIT:  if (txn_done) nxt = WS_ARM;
         default:  nxt = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= WS_IDLE;
         abort_q <= 1'b0;
         dto_q   <= 1'b0;
         dir_q   <= DIR_RX;
         beats_q <= '0;
      end else begin
         state <= nxt;
         if (load) begin
            abort_q <= 1'b0;
            dto_q   <= 1'b0;
            dir_q   <= job_dir;
         end else if (state == WS_DONE) begin
            abort_q <= 1'b0;
            dto_q   <= 1'b0;
         end else begin
            if (active && stop_pulse)           abort_q <= 1'b1;
            if (active && abort_q && dto_pulse) dto_q   <= 1'b1;
         end
         if ((state == WS_ARM) && !finish && go) beats_q <= beats_in;
      end
   end

endmodule

// File: rtl/wmark_burst_ctrl.sv
module wmark_burst_ctrl #(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 16,
   parameter int LVL_W       = 12,
   parameter int DATA_W      = 32,
   parameter bit BURST_FLOOR = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       job_start,
   input  logic [ADDR_W-1:0]          job_addr,
   input  logic [CNT_W-1:0]           job_bytes,
   input  logic                       job_dir,
   input  logic [LVL_W-1:0]           fifo_fill,
   input  logic [LVL_W-1:0]           fifo_space,
   input  logic [LVL_W-1:0]           rx_mark,
   input  logic [LVL_W-1:0]           tx_mark,
   input  logic [1:0]                 burst_sel,
   input  logic                       stop_pulse,
   input  logic                       dto_pulse,
   output logic                       req_valid,
   input  logic                       req_ready,
   output logic [ADDR_W-1:0]          req_addr,
   output logic [wmb_pkg::BEAT_W-1:0] req_beats,
   output logic                       req_write,
   input  logic                       txn_done,
   output logic                       job_done
);
   import wmb_pkg::*;

   localparam int BEAT_BYTES = DATA_W / 8;

   // elaboration-time parameter checks
   generate
      if ((DATA_W < 8) || ((DATA_W % 8) != 0)) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
      if (CNT_W < 8) begin : g_bad_cnt
         $error("CNT_W too small for the largest burst");
      end
      if (LVL_W < 4) begin : g_bad_lvl
         $error("LVL_W too small");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W too small");
      end
   endgenerate

   logic              load;
   logic              step;
   logic              abort_eff;
   logic              abort_q;
   logic              dir_q;
   logic              go;
   logic [BEAT_W-1:0] beats_pick;
   logic [CNT_W-1:0]  remaining;

   wmb_cursor #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (CNT_W),
      .BEAT_BYTES (BEAT_BYTES)
   ) u_cursor (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_addr  (job_addr),
      .load_bytes (job_bytes),
      .step       (step),
      .step_beats (req_beats),
      .addr       (req_addr),
      .remaining  (remaining)
   );

   wmb_gate #(
      .CNT_W       (CNT_W),
      .LVL_W       (LVL_W),
      .BEAT_BYTES  (BEAT_BYTES),
      .BURST_FLOOR (BURST_FLOOR)
   ) u_gate (
      .dir       (dir_q),
      .aborting  (abort_eff),
      .sel       (burst_sel),
      .remaining (remaining),
      .fill      (fifo_fill),
      .space     (fifo_space),
      .rx_mark   (rx_mark),
      .tx_mark   (tx_mark),
      .go        (go),
      .beats     (beats_pick)
   );

   wmb_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .job_start  (job_start),
      .job_dir    (job_dir),
      .stop_pulse (stop_pulse),
      .dto_pulse  (dto_pulse),
      .go         (go),
      .beats_in   (beats_pick),
      .remaining  (remaining),
      .req_ready  (req_ready),
      .txn_done   (txn_done),
      .load       (load),
      .step       (step),
      .abort_eff  (abort_eff),
      .abort_q    (abort_q),
      .dir_q      (dir_q),
      .req_valid  (req_valid),
      .req_beats  (req_beats),
      .job_done   (job_done)
   );

   assign req_write = (dir_q == DIR_RX);

endmodule

// File: rtl/wmb_checker.sv
module wmb_checker #(
   parameter int ADDR_W = 32,
   parameter int LVL_W  = 12
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       req_valid,
   input logic                       req_ready,
   input logic [ADDR_W-1:0]          req_addr,
   input logic [wmb_pkg::BEAT_W-1:0] req_beats,
   input logic                       req_write,
   input logic                       txn_done,
   input logic                       job_done,
   input logic [LVL_W-1:0]           fifo_fill,
   input logic [LVL_W-1:0]           fifo_space,
   input logic [LVL_W-1:0]           rx_mark,
   input logic [LVL_W-1:0]           tx_mark,
   input logic                       abort_flag
);
   logic pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pending <= 1'b0;
      else if (req_valid && req_ready) pending <= 1'b1;
      else if (txn_done)              pending <= 1'b0;
   end

   assert_rx_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(req_valid) && req_write && (req_beats != 5'd1)) |->
         ($past(fifo_fill) >= $past(rx_mark)));

   assert_tx_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(req_valid) && !req_write && (req_beats != 5'd1)) |->
         ($past(fifo_space) >= $past(tx_mark)));

   assert_beats_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ((req_beats == 5'd1) || (req_beats == 5'd4) ||
                     (req_beats == 5'd8) || (req_beats == 5'd16)));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      job_done |=> !job_done);

   assert_single_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(req_valid) && abort_flag) |-> (req_beats == 5'd1));

   assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> !req_valid);

   assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=>
         (req_valid && $stable(req_addr) && $stable(req_beats)));

endmodule

bind wmark_burst_ctrl wmb_checker #(
   .ADDR_W (ADDR_W),
   .LVL_W  (LVL_W)
) u_wmb_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .req_beats  (req_beats),
   .req_write  (req_write),
   .txn_done   (txn_done),
   .job_done   (job_done),
   .fifo_fill  (fifo_fill),
   .fifo_space (fifo_space),
   .rx_mark    (rx_mark),
   .tx_mark    (tx_mark),
   .abort_flag (abort_q)
);

// File: tb/test_wmark_burst_ctrl.sv
`timescale 1ns/1ps
module test_wmark_burst_ctrl;

   localparam int AW = 32;
   localparam int CW = 16;
   localparam int LW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          job_start = 1'b0;
   logic [AW-1:0] job_addr = '0;
   logic [CW-1:0] job_bytes = '0;
   logic          job_dir = 1'b0;
   logic [LW-1:0] fifo_fill = '0;
   logic [LW-1:0] fifo_space = '0;
   logic [LW-1:0] rx_mark = '0;
   logic [LW-1:0] tx_mark = '0;
   logic [1:0]    burst_sel = '0;
   logic          stop_pulse = 1'b0;
   logic          dto_pulse = 1'b0;
   logic          req_valid;
   logic          req_ready = 1'b0;
   logic [AW-1:0] req_addr;
   logic [4:0]    req_beats;
   logic          req_write;
   logic          txn_done = 1'b0;
   logic          job_done;

   int n_checks = 0;
   int n_fail   = 0;

   // expected job state
   logic [AW-1:0] exp_addr;
   int            exp_rem;
   bit            exp_abort;
   logic [1:0]    cur_sel;
   bit            cur_dir;
   int            cur_bytes;

   always #2 clk = ~clk;

   wmark_burst_ctrl i_wmark_burst_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .job_start  (job_start),
      .job_addr   (job_addr),
      .job_bytes  (job_bytes),
      .job_dir    (job_dir),
      .fifo_fill  (fifo_fill),
      .fifo_space (fifo_space),
      .rx_mark    (rx_mark),
      .tx_mark    (tx_mark),
      .burst_sel  (burst_sel),
      .stop_pulse (stop_pulse),
      .dto_pulse  (dto_pulse),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_beats  (req_beats),
      .req_write  (req_write),
      .txn_done   (txn_done),
      .job_done   (job_done)
   );

   function automatic int sel_beats(input logic [1:0] s);
      case (s)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction

   function automatic int model_beats(input int rem, input bit ab, input logic [1:0] s);
      if (ab || (sel_beats(s) * 4 > rem)) return 1;
      return sel_beats(s);
   endfunction

   function automatic int model_count(input int bytes, input logic [1:0] s);
      int r = bytes;
      int n = 0;
      while (r > 0) begin
         int b = model_beats(r, 1'b0, s) * 4;
         r = (r > b) ? r - b : 0;
         n++;
      end
      return n;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
   endtask

   task automatic begin_job(input logic [AW-1:0] a, input int bytes, input bit dir,
                            input logic [1:0] s);
      cur_sel = s; cur_dir = dir; cur_bytes = bytes;
      exp_addr = a; exp_rem = bytes; exp_abort = 1'b0;
      @(negedge clk);
      job_addr = a; job_bytes = CW'(bytes); job_dir = dir; burst_sel = s;
      job_start = 1'b1;
      @(negedge clk);
      job_start = 1'b0;
   endtask

   // act: 0 none, 1 pulse stop, 2 pulse dto while the transaction is outstanding
   task automatic serve(input int rdly, input int ddly, input int act, output bit finished);
      bit seen = 1'b0;
      bit ok_hold = 1'b1;
      bit ok_quiet = 1'b1;
      logic [AW-1:0] a0;
      logic [4:0] b0;
      int eb;
      int step;
      finished = 1'b0;
      while (!seen) begin
         @(negedge clk);
         if (job_done) begin finished = 1'b1; seen = 1'b1; end
         else if (req_valid) seen = 1'b1;
      end
      if (finished) return;
      eb = model_beats(exp_rem, exp_abort, cur_sel);
      check(req_addr == exp_addr, "R5", "request address", req_addr, exp_addr);
      check(req_beats == 5'(eb), exp_abort ? "R7" : "R4", "request beats", req_beats, eb);
      check(req_write == (cur_dir == 1'b0), "R5", "request direction", req_write, !cur_dir);
      a0 = req_addr; b0 = req_beats;
      for (int i = 0; i < rdly; i++) begin
         @(negedge clk);
         if (!req_valid || req_addr != a0 || req_beats != b0) ok_hold = 1'b0;
      end
      if (rdly > 0) check(ok_hold, "R10", "request held until ready", ok_hold, 1);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      step = int'(b0) * 4;
      exp_addr = exp_addr + AW'(step);
      exp_rem = (exp_rem > step) ? exp_rem - step : 0;
      for (int i = 0; i <= ddly; i++) begin
         if (i == 0 && act == 1) stop_pulse = 1'b1;
         if (i == 0 && act == 2) dto_pulse = 1'b1;
         @(negedge clk);
         stop_pulse = 1'b0;
         dto_pulse = 1'b0;
         if (req_valid) ok_quiet = 1'b0;
      end
      if (act == 1) exp_abort = 1'b1;
      check(ok_quiet, "R9", "no request while outstanding", !ok_quiet, 0);
      txn_done = 1'b1;
      @(negedge clk);
      txn_done = 1'b0;
   endtask

   task automatic finish_job(input int n0, input int stop_at, input int dto_at,
                             input string lbl);
      int n = n0;
      bit fin = 1'b0;
      int want = model_count(cur_bytes, cur_sel);
      while (!fin) begin
         int act = 0;
         if (n == stop_at) act = 1;
         else if (n == dto_at) act = 2;
         serve($urandom_range(0, 3), $urandom_range(0, 3), act, fin);
         if (!fin) n++;
      end
      if (exp_abort) begin
         check(n == dto_at + 1, "R8", "requests until transfer-over", n, dto_at + 1);
      end else begin
         check(n == want, lbl, "request count", n, want);
         check(exp_rem == 0, "R6", "bytes left at job end", exp_rem, 0);
      end
      @(negedge clk);
      check(!job_done, "R6", "job_done lasts one cycle", job_done, 0);
      check(!req_valid, "R8", "no request after job end", req_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      bit fin;
      void'($urandom(32'd4242));
      fifo_fill = 12'd2048; fifo_space = 12'd2048;
      rx_mark = 12'd32; tx_mark = 12'd32;
      repeat (3) @(negedge clk);
      check(!req_valid && !job_done, "R1", "outputs in reset", {req_valid, job_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!req_valid && !job_done, "R1", "outputs after reset", {req_valid, job_done}, 0);

      // receive watermark gating
      rx_mark = 12'd64; fifo_fill = 12'd60;
      begin_job(32'h1000, 128, 1'b0, 2'd2);
      repeat (20) @(negedge clk);
      check(!req_valid, "R2", "no write below rx mark", req_valid, 0);
      fifo_fill = 12'd64;
      repeat (2) @(negedge clk);
      check(req_valid, "R2", "write at rx mark", req_valid, 1);
      finish_job(0, -1, -1, "R4");

      // burst floor: mark below burst size
      rx_mark = 12'd8; fifo_fill = 12'd16;
      begin_job(32'h2000, 64, 1'b0, 2'd2);
      repeat (12) @(negedge clk);
      check(!req_valid, "R2", "no burst below burst size", req_valid, 0);
      fifo_fill = 12'd32;
      repeat (2) @(negedge clk);
      check(req_valid, "R2", "burst once size reached", req_valid, 1);
      finish_job(0, -1, -1, "R4");
      fifo_fill = 12'd2048;

      // transmit watermark gating
      tx_mark = 12'd100; fifo_space = 12'd99;
      begin_job(32'h3000, 128, 1'b1, 2'd3);
      repeat (20) @(negedge clk);
      check(!req_valid, "R3", "no read below tx mark", req_valid, 0);
      fifo_space = 12'd100;
      repeat (2) @(negedge clk);
      check(req_valid, "R3", "read at tx mark", req_valid, 1);
      finish_job(0, -1, -1, "R4");
      fifo_space = 12'd2048;

      // tail singles: 40 bytes with 8-beat bursts -> 8,1,1
      rx_mark = 12'd32;
      begin_job(32'h4000, 40, 1'b0, 2'd2);
      finish_job(0, -1, -1, "R4");

      // zero-byte job
      begin_job(32'h5000, 0, 1'b0, 2'd1);
      finish_job(0, -1, -1, "R6");

      // transfer-over without stop is ignored
      begin_job(32'h6000, 96, 1'b1, 2'd1);
      finish_job(0, -1, 0, "R11");

      // stop while idle is ignored
      @(negedge clk); stop_pulse = 1'b1;
      @(negedge clk); stop_pulse = 1'b0;
      begin_job(32'h7000, 128, 1'b0, 2'd3);
      finish_job(0, -1, -1, "R11");

      // read abort continuing past the end of the buffer
      begin_job(32'h8000, 256, 1'b0, 2'd3);
      finish_job(0, 0, 60, "R8");

      // write abort with single-beat gating
      tx_mark = 12'd32;
      begin_job(32'h9000, 256, 1'b1, 2'd2);
      serve(1, 1, 1, fin);
      fifo_space = 12'd3;
      repeat (15) @(negedge clk);
      check(!req_valid, "R7", "no single below one beat of space", req_valid, 0);
      fifo_space = 12'd4;
      repeat (2) @(negedge clk);
      check(req_valid, "R7", "single at one beat of space", req_valid, 1);
      fifo_space = 12'd2048;
      finish_job(1, -1, 5, "R8");

      // random jobs
      for (int j = 0; j < 30; j++) begin
         int bytes = 4 * $urandom_range(0, 100);
         logic [1:0] s = 2'($urandom_range(0, 3));
         bit d = 1'($urandom_range(0, 1));
         logic [AW-1:0] a = $urandom & 32'hFFFF_FFFC;
         int want = model_count(bytes, s);
         int st = -1;
         int dt = -1;
         rx_mark = 12'($urandom_range(4, 512));
         tx_mark = 12'($urandom_range(4, 512));
         if (want > 0 && $urandom_range(0, 3) == 0) begin
            st = $urandom_range(0, want - 1);
            dt = st + $urandom_range(1, 6);
         end
         begin_job(a, bytes, d, s);
         finish_job(0, st, dt, "R4");
      end

      summary();
      $finish;
   end

endmodule